// File: doc/BRIEF.md
# NMI Source Status Controller

This block holds the non-maskable interrupt source logic of a PC-style system behind two I/O ports. A status-and-control byte at port 061h reports the latched system-error status, the live level of the speaker timer output and a toggle that flips after each memory refresh. The same byte holds three control bits. One disables and clears the error source, one gates the timer output onto the speaker line, and one enables the timer. A single write-only mask bit, bit 7 of port 070h, blocks the NMI output globally.

The NMI output is a registered, masked copy of the latched error status. The error line, the refresh pulse and the timer output are asynchronous, so each passes through a synchronizer. An interrupt handler that finds a source still pending after servicing can mask and then unmask. The output then drops and rises again, and the processor sees a new rising edge.

Top module: `nmi_status_ctl`

## Requirements
- R1: After reset, the control bits 2..0 read 0, the NMI mask is set, and `nmi`, `spkr_data` and `tmr_gate` are 0.
- R2: A read of port 061h returns this layout: bit 7 is the error status, bit 5 is the synchronized timer level and bit 4 is the refresh toggle. Bits 6 and 3 are 0, and bits 2..0 are the control bits. Reads of any other address return 00h. Read data is valid on the cycle after the strobe.
- R3: Bits 2..0 of port 061h are read/write. Write data in bits 7, 5 and 4 (and in 6 and 3) has no effect on the register.
- R4: A falling edge on `serr_n` sets bit 7 while control bit 2 is 0. While bit 2 is 1, an error pulse leaves bit 7 at 0.
- R5: Writing control bit 2 as 1 clears bit 7 and holds it clear. Writing bit 2 as 0 again re-arms the source.
- R6: Bit 4 inverts once for each pulse on `refresh_done`.
- R7: `spkr_data` follows the timer level when control bit 1 is 1 and is 0 when bit 1 is 0.
- R8: `tmr_gate` equals control bit 0.
- R9: `nmi` is 1 exactly when bit 7 is set and the mask bit is 0. A write to port 070h loads the mask from data bit 7.
- R10: With an error still pending, writing the mask to 1 and then to 0 makes `nmi` fall and then rise.
- R11: A write to port 070h changes no bit of port 061h. A write to port 061h does not change the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | I/O port address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| serr_n | input | 1 | Active-low system error pulse, asynchronous |
| refresh_done | input | 1 | Refresh completion pulse, asynchronous |
| tmr_out | input | 1 | Speaker timer output level, asynchronous |
| nmi | output | 1 | NMI request level |
| spkr_data | output | 1 | Gated speaker data |
| tmr_gate | output | 1 | Speaker timer gate enable |

## Verification
The hardest state to reach is a mask toggle that happens while the error status is latched and the source is still enabled. The NMI must fall and then rise again without a new error pulse. The stimulus reaches it in order: it arms the source with bit 2 at 0, pulses `serr_n`, unmasks, and confirms that `nmi` is high. It then writes the mask to 1 and back to 0, checking `nmi` after each write. Random writes with random upper data bits run between these directed steps. They show that the read-only positions and the mask remain unchanged by ordinary control writes.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
  localparam int DW        = 8;
  localparam int ST_ERR    = 7;
  localparam int ST_TMR    = 5;
  localparam int ST_TOG    = 4;
  localparam int CT_ERRDIS = 2;
  localparam int CT_SPK    = 1;
  localparam int CT_GATE   = 0;
  localparam int MASK_BIT  = 7;

  typedef struct packed {
    logic errdis;
    logic spk_en;
    logic gate_en;
  } ctl_t;
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nmi_src_ctl.sv
module nmi_src_ctl
  import nmi_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_wr,
  input  logic [2:0]    ctl_wdata,
  input  logic          err_n_s,
  input  logic          ref_s,
  input  logic          tmr_s,
  output logic [DW-1:0] status,
  output logic          err_stat,
  output logic          spkr,
  output logic          gate
);
  ctl_t ctl;
  logic err_prev, ref_prev, tog;
  logic err_fall, ref_rise;

  assign err_fall = err_prev & ~err_n_s;
  assign ref_rise = ref_s & ~ref_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl      <= '0;
      err_prev <= 1'b1;
      ref_prev <= 1'b0;
      tog      <= 1'b0;
      err_stat <= 1'b0;
      spkr     <= 1'b0;
    end else begin
      err_prev <= err_n_s;
      ref_prev <= ref_s;
      if (ctl_wr) ctl <= ctl_t'(ctl_wdata);
      if (ref_rise) tog <= ~tog;
      if (ctl_wr && ctl_wdata[CT_ERRDIS]) err_stat <= 1'b0;
      else if (err_fall && !ctl.errdis)   err_stat <= 1'b1;
      spkr <= tmr_s & ctl.spk_en;
    end
  end

  assign gate = ctl.gate_en;

  always_comb begin
    status            = '0;
    status[ST_ERR]    = err_stat;
    status[ST_TMR]    = tmr_s;
    status[ST_TOG]    = tog;
    status[CT_ERRDIS] = ctl.errdis;
    status[CT_SPK]    = ctl.spk_en;
    status[CT_GATE]   = ctl.gate_en;
  end

  a_r4_err_set: assert property (@(posedge clk) disable iff (rst)
    (err_fall && !ctl.errdis && !(ctl_wr && ctl_wdata[CT_ERRDIS])) |=> err_stat);
  a_r5_err_clear: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_wdata[CT_ERRDIS]) |=> !err_stat);
  a_r5_disabled_hold: assert property (@(posedge clk) disable iff (rst)
    (ctl.errdis && !err_stat) |=> !err_stat);
  a_r6_toggle: assert property (@(posedge clk) disable iff (rst)
    ref_rise |=> (tog != $past(tog)));
  a_r7_spkr_off: assert property (@(posedge clk) disable iff (rst)
    !ctl.spk_en |=> !spkr);
endmodule

// File: rtl/nmi_gen.sv
module nmi_gen (
  input  logic clk,
  input  logic rst,
  input  logic mask_wr,
  input  logic mask_val,
  input  logic err_stat,
  output logic nmi
);
  logic mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= 1'b1;
      nmi  <= 1'b0;
    end else begin
      if (mask_wr) mask <= mask_val;
      nmi <= err_stat & ~mask;
    end
  end

  a_r9_masked_low: assert property (@(posedge clk) disable iff (rst)
    mask |=> !nmi);
  a_r9_pending_high: assert property (@(posedge clk) disable iff (rst)
    (err_stat && !mask) |=> nmi);
  a_r11_mask_hold: assert property (@(posedge clk) disable iff (rst)
    !mask_wr |=> (mask == $past(mask)));
endmodule

// File: rtl/nmi_status_ctl.sv
module nmi_status_ctl
  import nmi_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] CTRL_PORT   = 16'h0061,
  parameter logic [15:0] MASK_PORT   = 16'h0070,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [DW-1:0]     io_wdata,
  output logic [DW-1:0]     io_rdata,
  input  logic              serr_n,
  input  logic              refresh_done,
  input  logic              tmr_out,
  output logic              nmi,
  output logic              spkr_data,
  output logic              tmr_gate
);
  localparam logic [ADDR_W-1:0] CTRL_A = CTRL_PORT[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] MASK_A = MASK_PORT[ADDR_W-1:0];

  logic err_n_s, ref_s, tmr_s, err_stat;
  logic hit_ctrl, hit_mask;
  logic [DW-1:0] status;
  logic unused_wbits;

  assign hit_ctrl     = (io_addr == CTRL_A);
  assign hit_mask     = (io_addr == MASK_A);
  assign unused_wbits = ^io_wdata[6:3];

  nmi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_err (
    .clk(clk), .rst(rst), .d(serr_n), .q(err_n_s));
  nmi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_ref (
    .clk(clk), .rst(rst), .d(refresh_done), .q(ref_s));
  nmi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_tmr (
    .clk(clk), .rst(rst), .d(tmr_out), .q(tmr_s));

  nmi_src_ctl u_src (
    .clk(clk), .rst(rst),
    .ctl_wr(io_wr && hit_ctrl), .ctl_wdata(io_wdata[2:0]),
    .err_n_s(err_n_s), .ref_s(ref_s), .tmr_s(tmr_s),
    .status(status), .err_stat(err_stat),
    .spkr(spkr_data), .gate(tmr_gate));

  nmi_gen u_gen (
    .clk(clk), .rst(rst),
    .mask_wr(io_wr && hit_mask), .mask_val(io_wdata[MASK_BIT]),
    .err_stat(err_stat), .nmi(nmi));

  always_ff @(posedge clk) begin
    if (rst)                   io_rdata <= '0;
    else if (io_rd && hit_ctrl) io_rdata <= status;
    else                       io_rdata <= '0;
  end

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (io_rdata[6] == 1'b0) && (io_rdata[3] == 1'b0));
  a_r2_other_addr: assert property (@(posedge clk) disable iff (rst)
    !(io_rd && hit_ctrl) |=> (io_rdata == '0));
  a_r8_gate_write: assert property (@(posedge clk) disable iff (rst)
    (io_wr && hit_ctrl) |=> (tmr_gate == $past(io_wdata[0])));
endmodule

// File: tb/tb_nmi_status_ctl.sv
module tb_nmi_status_ctl;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic [15:0] io_addr = '0;
  logic io_rd = 0, io_wr = 0;
  logic [7:0] io_wdata = '0, io_rdata;
  logic serr_n = 1, refresh_done = 0, tmr_out = 0;
  logic nmi, spkr_data, tmr_gate;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [2:0] m_ctl = '0;
  logic m_err = 0, m_tog = 0, m_mask = 1;

  nmi_status_ctl dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] exp_rd(logic e, logic t, logic g, logic [2:0] c);
    return {e, 1'b0, t, g, 1'b0, c};
  endfunction

  function automatic logic exp_nmi(logic e, logic m);
    return e & ~m;
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
    if (a == 16'h0061) begin
      m_ctl = d[2:0];
      if (d[2]) m_err = 0;
    end
    if (a == 16'h0070) m_mask = d[7];
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1;
    @(negedge clk); io_rd = 0; d = io_rdata;
  endtask

  task automatic err_pulse();
    @(negedge clk); serr_n = 0;
    @(negedge clk); serr_n = 1;
    if (!m_ctl[2]) m_err = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic ref_pulse();
    @(negedge clk); refresh_done = 1;
    @(negedge clk); refresh_done = 0;
    m_tog = ~m_tog;
    repeat (6) @(negedge clk);
  endtask

  task automatic set_tmr(logic v);
    @(negedge clk); tmr_out = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd(16'h0061, d);
    check("R1 ctl", {5'd0, d[2:0]}, 8'h00);
    check("R1 nmi", {7'd0, nmi}, 8'h00);
    check("R1 spkr", {7'd0, spkr_data}, 8'h00);
    check("R1 gate", {7'd0, tmr_gate}, 8'h00);

    // R2 other address reads zero
    rd(16'h0062, d);
    check("R2 other addr", d, 8'h00);

    // R4 pulse while disabled is ignored
    wr(16'h0061, 8'h04);
    err_pulse();
    rd(16'h0061, d);
    check("R4 disabled ignore", d, exp_rd(m_err, 0, m_tog, m_ctl));

    // R4 arm and latch, nmi still masked (R9)
    wr(16'h0061, 8'h00);
    err_pulse();
    rd(16'h0061, d);
    check("R4 latch", d, exp_rd(m_err, 0, m_tog, m_ctl));
    check("R9 masked", {7'd0, nmi}, {7'd0, exp_nmi(m_err, m_mask)});

    // R9 unmask
    wr(16'h0070, 8'h00);
    check("R9 unmasked", {7'd0, nmi}, {7'd0, exp_nmi(m_err, m_mask)});

    // R10 mask then unmask re-creates the edge
    wr(16'h0070, 8'h80);
    check("R10 low", {7'd0, nmi}, 8'h00);
    wr(16'h0070, 8'h00);
    check("R10 high", {7'd0, nmi}, 8'h01);

    // R11 mask write leaves port 061h alone
    wr(16'h0070, 8'h7F);
    rd(16'h0061, d);
    check("R11 ctl kept", d, exp_rd(m_err, 0, m_tog, m_ctl));
    check("R11 mask loaded", {7'd0, nmi}, {7'd0, exp_nmi(m_err, m_mask)});
    wr(16'h0070, 8'h00);

    // R5 clear via bit 2, re-arm
    wr(16'h0061, 8'h04);
    rd(16'h0061, d);
    check("R5 cleared", d, exp_rd(m_err, 0, m_tog, m_ctl));
    check("R5 nmi drop", {7'd0, nmi}, 8'h00);
    wr(16'h0061, 8'h00);
    rd(16'h0061, d);
    check("R5 stays clear", d, exp_rd(m_err, 0, m_tog, m_ctl));

    // R6 refresh toggle
    for (int i = 0; i < 3; i++) begin
      ref_pulse();
      rd(16'h0061, d);
      check("R6 toggle", d, exp_rd(m_err, 0, m_tog, m_ctl));
    end

    // R3 R7 R8 R11 random control writes
    for (int i = 0; i < 40; i++) begin
      logic [7:0] w;
      logic t;
      w = 8'($urandom);
      w[2] = ($urandom % 4) == 0;
      t = 1'($urandom);
      set_tmr(t);
      wr(16'h0061, w);
      if (($urandom % 3) == 0) err_pulse();
      rd(16'h0061, d);
      check("R3 readback", d, exp_rd(m_err, t, m_tog, m_ctl));
      check("R7 spkr", {7'd0, spkr_data}, {7'd0, t & m_ctl[1]});
      check("R8 gate", {7'd0, tmr_gate}, {7'd0, m_ctl[0]});
      check("R11 nmi", {7'd0, nmi}, {7'd0, exp_nmi(m_err, m_mask)});
    end

    done = 1;
    summary();
  end
endmodule